// File: doc/BRIEF.md
# Three-Moduli Residue-to-Binary Converter

This block turns a number held as three residues back into its ordinary weighted binary form. The modulus set is {2^N, 2^(N+1)+1, 2^(N+1)-1}, with N a parameter of at least 1. The three moduli share no common factor, so any value below their product M has exactly one residue triple.

The conversion uses no multipliers and no lookup storage. Three operand vectors of 2N+2 bits are built from the residues by fixed wiring and inversion. A carry-save stage reduces them to two vectors, and its top carry wraps around to bit 0. A final adder modulo 2^(2N+2)-1 then produces an intermediate Y, and the result is X = 2^N·Y + x1. Since x1 only fills the low N bits, that last step is pure concatenation.

A compile-time parameter picks the final adder. The compact variant is one carry-propagate adder whose carry-out is fed back in. The fast variant runs two adders in parallel, one with carry-in 0 and one with carry-in 1, and the carry-out of the first selects between them. The block is purely combinational. It does not check that its inputs are in range.

Top module: `rns3_reverse_conv`

## Requirements
- R1: The low N bits of `value_out` always equal `x1_res`.
- R2: For residues in range (x1 < 2^N, x2 < 2^(N+1)+1, x3 < 2^(N+1)-1), `value_out` is the unique X < M with X mod 2^N = x1, X mod (2^(N+1)+1) = x2 and X mod (2^(N+1)-1) = x3.
- R3: The upper 2N+2 bits of `value_out` (Y) are never all ones. A modular sum equal to 2^(2N+2)-1 is returned as zero, so Y lies in [0, 2^(2N+2)-2].
- R4: For N=3, the residues (2,5,7) convert to 1042.
- R5: The compact (ADDER_COMPACT) and fast (ADDER_FAST) final-adder variants give identical outputs for every in-range input.
- R6: The all-zero residue triple gives 0, and the residue triple of M-1 gives M-1.
- R7: The output follows an input change within the same time step, with no clock and no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x1_res | input | N | Residue modulo 2^N |
| x2_res | input | N+2 | Residue modulo 2^(N+1)+1 |
| x3_res | input | N+1 | Residue modulo 2^(N+1)-1 |
| value_out | output | 3N+2 | Weighted binary value, Y above x1 |

## Verification
The bench builds the converter with N=2, 3 and 4, and builds each size in both final-adder variants. These sizes are small enough that every value in [0, M-1] can be swept, 252, 2040 and 16368 values, with the residues taken by the modulo operator and the result compared against the value itself. The sweep also reaches every point where the modular sum lands exactly on 2^(2N+2)-1, which is the case the zero normalisation must handle. At N=3, a table of hand-worked triples adds the reference conversion, the endpoints of the range and triples with a single nonzero residue.

// File: rtl/rnsrc_pkg.sv
package rnsrc_pkg;

  typedef enum logic {
    ADDER_COMPACT = 1'b0,
    ADDER_FAST    = 1'b1
  } rnsrc_adder_e;

  // value reduced modulo (2^w - 1), w below 63
  function automatic longint unsigned fold_mod(input longint unsigned v, input int unsigned w);
    longint unsigned m;
    m = (64'd1 << w) - 64'd1;
    return v % m;
  endfunction

  // product of the three moduli for a given N
  function automatic longint unsigned range_of(input int unsigned n);
    return (64'd1 << n) * ((64'd1 << (n + 1)) + 64'd1) * ((64'd1 << (n + 1)) - 64'd1);
  endfunction

endpackage

// File: rtl/rnsrc_operand_map.sv
module rnsrc_operand_map #(
  parameter int N = 8,
  localparam int W = 2 * N + 2
) (
  input  logic [N-1:0] x1_res,
  input  logic [N+1:0] x2_res,
  input  logic [N:0]   x3_res,
  output logic [W-1:0] op_inv,
  output logic [W-1:0] op_rot,
  output logic [W-1:0] op_dup
);

  // negated residues packed side by side (one's complement negation)
  assign op_inv = {~x1_res, ~x2_res};

  // x2 scaled by 2^(N+1) modulo 2^W-1: low N+1 bits moved up, top bit wrapped
  assign op_rot = {x2_res[N:0], {N{1'b0}}, x2_res[N+1]};

  // x3 multiplied by 2^(N+1)+1 modulo 2^W-1: two copies
  assign op_dup = {x3_res, x3_res};

endmodule

// File: rtl/rnsrc_csa_eac.sv
module rnsrc_csa_eac #(
  parameter int N = 8,
  localparam int W = 2 * N + 2
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_vec,
  output logic [W-1:0] cry_vec
);
  import rnsrc_pkg::*;

  logic [W-1:0] cry_raw;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i >= 1 && i <= N) begin : g_half
      // in_b is zero at these positions: half adder on the other two
      assign sum_vec[i] = in_a[i] ^ in_c[i];
      assign cry_raw[i] = in_a[i] & in_c[i];
    end else begin : g_full
      assign sum_vec[i] = in_a[i] ^ in_b[i] ^ in_c[i];
      assign cry_raw[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
    end
  end

  // carries move up one place; the top one wraps into bit 0
  assign cry_vec = {cry_raw[W-2:0], cry_raw[W-1]};

  always_comb begin
    // R2
    csa_fold_chk: assert (fold_mod(longint'(sum_vec) + longint'(cry_vec), W) ==
                          fold_mod(longint'(in_a) + longint'(in_b) + longint'(in_c), W))
      else $error("carry-save stage lost value modulo 2^W-1");
    // R2
    hole_zero_chk: assert (in_b[N:1] == '0)
      else $error("half-adder positions received a nonzero operand bit");
  end

endmodule

// File: rtl/rnsrc_modadd.sv
module rnsrc_modadd
  import rnsrc_pkg::*;
#(
  parameter int           W    = 18,
  parameter rnsrc_adder_e MODE = ADDER_COMPACT
) (
  input  logic [W-1:0] in_p,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] y_out
);

  logic [W-1:0] raw_sum;
  logic         wrap_zero;

  if (MODE == ADDER_COMPACT) begin : g_compact
    logic [W:0] first;
    assign first   = {1'b0, in_p} + {1'b0, in_q};
    // feed the carry-out back in as carry-in
    assign raw_sum = first[W-1:0] + {{(W-1){1'b0}}, first[W]};
  end else begin : g_fast
    logic [W:0]   path0;
    logic [W-1:0] path1;
    assign path0   = {1'b0, in_p} + {1'b0, in_q};
    assign path1   = in_p + in_q + {{(W-1){1'b0}}, 1'b1};
    assign raw_sum = path0[W] ? path1 : path0[W-1:0];

    always_comb begin
      // R5
      twin_step_chk: assert (path1 == path0[W-1:0] + {{(W-1){1'b0}}, 1'b1})
        else $error("parallel adders disagree by more than the carry-in");
    end
  end

  // all ones is the second code for zero
  assign wrap_zero = &raw_sum;
  assign y_out     = wrap_zero ? '0 : raw_sum;

  always_comb begin
    // R3
    no_all_ones_chk: assert (y_out != {W{1'b1}})
      else $error("modular sum left as all ones");
    // R2
    modadd_fold_chk: assert (longint'(y_out) == fold_mod(longint'(in_p) + longint'(in_q), W))
      else $error("final adder result wrong modulo 2^W-1");
  end

endmodule

// File: rtl/rns3_reverse_conv.sv
module rns3_reverse_conv
  import rnsrc_pkg::*;
#(
  parameter int           N    = 8,
  parameter rnsrc_adder_e MODE = ADDER_COMPACT
) (
  input  logic [N-1:0]   x1_res,
  input  logic [N+1:0]   x2_res,
  input  logic [N:0]     x3_res,
  output logic [3*N+1:0] value_out
);

  localparam int W = 2 * N + 2;
  localparam longint unsigned P2 = (64'd1 << (N + 1)) + 64'd1;
  localparam longint unsigned P3 = (64'd1 << (N + 1)) - 64'd1;
  localparam longint unsigned M  = range_of(N);

  logic [W-1:0] op_inv, op_rot, op_dup;
  logic [W-1:0] csa_sum, csa_cry;
  logic [W-1:0] y_val;

  rnsrc_operand_map #(.N(N)) u_map (
    .x1_res (x1_res),
    .x2_res (x2_res),
    .x3_res (x3_res),
    .op_inv (op_inv),
    .op_rot (op_rot),
    .op_dup (op_dup)
  );

  rnsrc_csa_eac #(.N(N)) u_csa (
    .in_a    (op_inv),
    .in_b    (op_rot),
    .in_c    (op_dup),
    .sum_vec (csa_sum),
    .cry_vec (csa_cry)
  );

  rnsrc_modadd #(.W(W), .MODE(MODE)) u_add (
    .in_p  (csa_sum),
    .in_q  (csa_cry),
    .y_out (y_val)
  );

  assign value_out = {y_val, x1_res};

  always_comb begin
    if (longint'(x2_res) < P2 && longint'(x3_res) < P3) begin
      // R2
      residue_match_chk: assert (longint'(value_out) % P2 == longint'(x2_res) &&
                                 longint'(value_out) % P3 == longint'(x3_res) &&
                                 longint'(value_out) < M)
        else $error("converted value does not reproduce its residues");
    end
  end

endmodule

// File: tb/rns3_reverse_conv_tb.sv
module rnsrc_sweep_unit
  import rnsrc_pkg::*;
#(
  parameter int N = 2
) (
  output int   sw_checks,
  output int   sw_fails,
  output logic sw_done
);
  localparam longint unsigned P1 = 64'd1 << N;
  localparam longint unsigned P2 = (64'd1 << (N + 1)) + 64'd1;
  localparam longint unsigned P3 = (64'd1 << (N + 1)) - 64'd1;
  localparam longint unsigned M  = P1 * P2 * P3;

  logic [N-1:0]   s1;
  logic [N+1:0]   s2;
  logic [N:0]     s3;
  logic [3*N+1:0] out_c, out_f;

  rns3_reverse_conv #(.N(N), .MODE(ADDER_COMPACT)) u_dut (
    .x1_res(s1), .x2_res(s2), .x3_res(s3), .value_out(out_c));
  rns3_reverse_conv #(.N(N), .MODE(ADDER_FAST)) u_dut_fast (
    .x1_res(s1), .x2_res(s2), .x3_res(s3), .value_out(out_f));

  initial begin
    sw_checks = 0;
    sw_fails  = 0;
    sw_done   = 1'b0;
    s1 = '0; s2 = '0; s3 = '0;
    #3;
    for (longint unsigned v = 0; v < M; v++) begin
      s1 = N'(v % P1);
      s2 = (N+2)'(v % P2);
      s3 = (N+1)'(v % P3);
      #1;
      // R2 R3 sweep, compact variant
      sw_checks++;
      if (longint'(out_c) != v) begin
        sw_fails++;
        $display("FAIL R2 N=%0d compact: actual %0d expected %0d", N, out_c, v);
      end
      // R5 fast variant matches the value and the compact one
      sw_checks++;
      if (longint'(out_f) != v || out_f != out_c) begin
        sw_fails++;
        $display("FAIL R5 N=%0d fast: actual %0d expected %0d", N, out_f, v);
      end
    end
    sw_done = 1'b1;
  end
endmodule

module rns3_reverse_conv_tb;
  import rnsrc_pkg::*;

  localparam int N  = 3;
  localparam int XW = 3 * N + 2;
  localparam int NV = 10;
  // {x1, x2, x3, expected X} for N=3, M=2040
  localparam int VEC [NV][4] = '{
    '{2, 5, 7, 1042},
    '{0, 0, 0, 0},
    '{7, 16, 14, 2039},
    '{1, 1, 1, 1},
    '{0, 8, 8, 8},
    '{7, 0, 0, 255},
    '{4, 0, 0, 1020},
    '{0, 1, 0, 120},
    '{0, 0, 1, 136},
    '{7, 7, 7, 7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [N-1:0]  x1;
  logic [N+1:0]  x2;
  logic [N:0]    x3;
  logic [XW-1:0] out_c, out_f;

  rns3_reverse_conv #(.N(N), .MODE(ADDER_COMPACT)) u_dut (
    .x1_res(x1), .x2_res(x2), .x3_res(x3), .value_out(out_c));
  rns3_reverse_conv #(.N(N), .MODE(ADDER_FAST)) u_dut_fast (
    .x1_res(x1), .x2_res(x2), .x3_res(x3), .value_out(out_f));

  int   c2, f2, c3, f3, c4, f4;
  logic d2, d3, d4;
  rnsrc_sweep_unit #(.N(2)) u_sw2 (.sw_checks(c2), .sw_fails(f2), .sw_done(d2));
  rnsrc_sweep_unit #(.N(3)) u_sw3 (.sw_checks(c3), .sw_fails(f3), .sw_done(d3));
  rnsrc_sweep_unit #(.N(4)) u_sw4 (.sw_checks(c4), .sw_fails(f4), .sw_done(d4));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    x1 = '0; x2 = '0; x3 = '0;
    repeat (2) @(negedge clk);
    // R6 zero residues give zero, reset state of the harness
    check("R6 zero", longint'(out_c), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      x1 = N'(VEC[i][0]);
      x2 = (N+2)'(VEC[i][1]);
      x3 = (N+1)'(VEC[i][2]);
      @(negedge clk);
      // R2 R4 R6 table value, compact variant
      check("R2 table compact", longint'(out_c), longint'(VEC[i][3]));
      // R5 fast variant
      check("R5 table fast", longint'(out_f), longint'(VEC[i][3]));
      // R1 low bits carry x1
      check("R1 low bits", longint'(out_c[N-1:0]), longint'(VEC[i][0]));
    end

    // R4 reference triple
    @(posedge clk);
    x1 = 3'd2; x2 = 5'd5; x3 = 4'd7;
    @(negedge clk);
    check("R4 (2,5,7)", longint'(out_c), 1042);

    // R3 modular sum lands on all ones: Y must read zero
    x1 = 3'd7; x2 = 5'd7; x3 = 4'd7;
    @(negedge clk);
    check("R3 Y compact", longint'(out_c[XW-1:N]), 0);
    check("R3 Y fast", longint'(out_f[XW-1:N]), 0);

    // R6 top of range
    x1 = 3'd7; x2 = 5'd16; x3 = 4'd14;
    @(negedge clk);
    check("R6 max", longint'(out_f), 2039);

    // R7 output follows inputs without a clock edge
    #1;
    x1 = 3'd4; x2 = 5'd0; x3 = 4'd0;
    #1;
    check("R7 no clock", longint'(out_c), 1020);

    wait (d2 && d3 && d4);
    checks += c2 + c3 + c4;
    fails  += f2 + f3 + f4;
    finish_run();
  end

endmodule